// File: doc/BRIEF.md
# RGB Colour Palette with Auto-Stepping Host Port

This block is a colour palette built from three tables, one for each of red, green and blue. Each table has 256 entries, and each entry is 4 bits wide. A host programs the palette through two byte-wide registers. The index register picks a palette entry. The data register moves colour components in and out. Internally the block keeps a pointer that holds an entry number and a colour selector. Every data access moves the pointer from red to green to blue, and then on to red of the next entry. The host therefore programs a run of entries by writing the index once and then streaming data bytes.

Red and green writes go into staging registers. The table changes only when the blue component arrives, and at that moment the whole triple for the entry is written in one step. A separate pixel port serves the display pipeline. It accepts an 8-bit pixel index under valid/ready flow control and returns the 12-bit {R,G,B} colour one cycle later. A colour that is stalled on the output is held until it is taken. While the output holds a stalled colour, the block accepts no new pixel index.

Top module: `rgb_palette`

## Requirements
- R1: After reset the pointer is at entry 0 with red selected, `rgb_valid` is low and `px_ready` is high. Reset does not clear the tables.
- R2: A write to the index register (`reg_idx_sel` and `reg_wr`) sets the entry to `reg_wdata` and selects red.
- R3: Each data access (`reg_data_sel` with `reg_wr` or `reg_rd`) steps the pointer red to green to blue, and from blue to red of entry+1. After index 03h and three data writes, R[3], G[3] and B[3] are loaded and the pointer is at red of entry 4.
- R4: Stepping past blue of entry 255 moves the pointer to entry 0, red.
- R5: Red and green writes do not change the table. A blue write updates all three components of the entry in one step. A component that was not written since the last index write or commit keeps its table value.
- R6: A colour value travels in bits 7:4 of the data byte. Bits 3:0 are ignored on write and read back as zero.
- R7: A data read returns the table value for the current entry and component, never a staged value, and it advances the pointer like a write.
- R8: An index write discards any staged red or green value, so no table update results from it.
- R9: A pixel index accepted on `px_valid && px_ready` gives `rgb_out = {R[11:8], G[7:4], B[3:0]}` with `rgb_valid` high on the next cycle.
- R10: `px_ready` equals `!rgb_valid || rgb_ready`. While `rgb_valid && !rgb_ready`, both `rgb_valid` and `rgb_out` hold.
- R11: A pixel index accepted in the same cycle as a blue commit to that entry returns the colour from before the commit. Later lookups return the committed colour.
- R12: When an index write and a data access fall in the same cycle, the index write wins. The data access neither stages, commits nor steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx_sel | input | 1 | Selects the index register |
| reg_data_sel | input | 1 | Selects the data register |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (data register) |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Current component in bits 7:4, zeros below |
| px_valid | input | 1 | Pixel index valid |
| px_ready | output | 1 | Pixel index accepted when high |
| px_index | input | 8 | Pixel palette index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_ready | input | 1 | Downstream takes colour when high |
| rgb_out | output | 12 | Colour as {R,G,B} |

## Verification
The blue commit and a pixel lookup of the same entry can land on one clock edge. The test provokes this by driving the blue data write and `px_valid` for that entry in the same cycle. It then expects the pre-commit colour on the output, and the new colour from the following lookup. A second collision pairs an index write with a data write in one cycle. It is judged by reading the entry back and looking it up, which shows that the pointer moved to the new entry and that the data byte left no trace.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_R = 2'd0,
    SEL_G = 2'd1,
    SEL_B = 2'd2
  } color_sel_e;
endpackage

// File: rtl/pal_pointer.sv
module pal_pointer
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             data_acc,
  output logic [IDX_W-1:0] entry,
  output color_sel_e       sel
);
  logic adv;
  assign adv = data_acc && !idx_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry <= '0;
      sel   <= SEL_R;
    end else if (idx_wr) begin
      entry <= idx_val;
      sel   <= SEL_R;
    end else if (adv) begin
      unique case (sel)
        SEL_R:   sel <= SEL_G;
        SEL_G:   sel <= SEL_B;
        default: begin
          sel   <= SEL_R;
          entry <= entry + 1'b1;
        end
      endcase
    end
  end

  p_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (entry == $past(idx_val)) && (sel == SEL_R));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel == SEL_R) |=> (sel == SEL_G) && (entry == $past(entry)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sel == SEL_B && entry == {IDX_W{1'b1}}) |=> (entry == '0) && (sel == SEL_R));
endmodule

// File: rtl/pal_stage.sv
module pal_stage #(
  parameter int COMP_W = 4,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_r,
  input  logic              wr_g,
  input  logic              wr_b,
  input  logic [COMP_W-1:0] wval,
  input  logic [RGB_W-1:0]  cur_rgb,
  output logic              commit,
  output logic [RGB_W-1:0]  commit_rgb
);
  logic [COMP_W-1:0] stg_r, stg_g;
  logic              r_ok, g_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ok  <= 1'b0;
      g_ok  <= 1'b0;
      stg_r <= '0;
      stg_g <= '0;
    end else if (clear || wr_b) begin
      r_ok <= 1'b0;
      g_ok <= 1'b0;
    end else begin
      if (wr_r) begin
        stg_r <= wval;
        r_ok  <= 1'b1;
      end
      if (wr_g) begin
        stg_g <= wval;
        g_ok  <= 1'b1;
      end
    end
  end

  assign commit     = wr_b && !clear;
  assign commit_rgb = {r_ok ? stg_r : cur_rgb[RGB_W-1 -: COMP_W],
                       g_ok ? stg_g : cur_rgb[2*COMP_W-1 -: COMP_W],
                       wval};

  p_stage_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !r_ok && !g_ok);
endmodule

// File: rtl/pal_table.sv
module pal_table #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 4,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int RGB_W   = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wrgb,
  input  logic [IDX_W-1:0] host_addr,
  output logic [RGB_W-1:0] host_rgb,
  input  logic [IDX_W-1:0] px_addr,
  output logic [RGB_W-1:0] px_rgb
);
  for (genvar c = 0; c < 3; c++) begin : g_comp
    localparam int LSB = (2 - c) * COMP_W;
    logic [COMP_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wrgb[LSB +: COMP_W];
    end

    assign host_rgb[LSB +: COMP_W] = mem[host_addr];
    assign px_rgb[LSB +: COMP_W]   = mem[px_addr];
  end
endmodule

// File: rtl/rgb_palette.sv
module rgb_palette
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 4,
  parameter int BUS_W  = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_idx_sel,
  input  logic             reg_data_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             px_valid,
  output logic             px_ready,
  input  logic [IDX_W-1:0] px_index,
  output logic             rgb_valid,
  input  logic             rgb_ready,
  output logic [RGB_W-1:0] rgb_out
);
  logic              idx_wr, data_acc, data_wr;
  logic [IDX_W-1:0]  entry;
  color_sel_e        sel;
  logic [COMP_W-1:0] wval, host_comp;
  logic [RGB_W-1:0]  host_rgb, px_rgb, commit_rgb;
  logic              commit;

  assign idx_wr   = reg_idx_sel && reg_wr;
  assign data_acc = reg_data_sel && (reg_wr || reg_rd) && !idx_wr;
  assign data_wr  = reg_data_sel && reg_wr && !idx_wr;
  assign wval     = reg_wdata[BUS_W-1 -: COMP_W];

  pal_pointer #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .idx_val  (reg_wdata[IDX_W-1:0]),
    .data_acc (data_acc),
    .entry    (entry),
    .sel      (sel)
  );

  pal_stage #(.COMP_W(COMP_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (idx_wr),
    .wr_r       (data_wr && sel == SEL_R),
    .wr_g       (data_wr && sel == SEL_G),
    .wr_b       (data_wr && sel == SEL_B),
    .wval       (wval),
    .cur_rgb    (host_rgb),
    .commit     (commit),
    .commit_rgb (commit_rgb)
  );

  pal_table #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_tbl (
    .clk       (clk),
    .we        (commit),
    .waddr     (entry),
    .wrgb      (commit_rgb),
    .host_addr (entry),
    .host_rgb  (host_rgb),
    .px_addr   (px_index),
    .px_rgb    (px_rgb)
  );

  always_comb begin
    unique case (sel)
      SEL_R:   host_comp = host_rgb[RGB_W-1 -: COMP_W];
      SEL_G:   host_comp = host_rgb[2*COMP_W-1 -: COMP_W];
      default: host_comp = host_rgb[COMP_W-1:0];
    endcase
  end
  assign reg_rdata = {host_comp, {(BUS_W-COMP_W){1'b0}}};

  assign px_ready = !rgb_valid || rgb_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb_out   <= '0;
    end else if (px_ready) begin
      rgb_valid <= px_valid;
      if (px_valid) rgb_out <= px_rgb;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> rgb_valid && $stable(rgb_out));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |=> rgb_valid);
endmodule

// File: tb/rgb_palette_bench.sv
module rgb_palette_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_idx_sel = 0, reg_data_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        px_valid = 0, px_ready, rgb_valid, rgb_ready = 1;
  logic [7:0]  px_index = '0;
  logic [11:0] rgb_out;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  rgb_palette u_rgb_palette (
    .clk, .rst_n, .reg_idx_sel, .reg_data_sel, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .px_valid, .px_ready, .px_index, .rgb_valid, .rgb_ready, .rgb_out
  );

  // {pixel index, expected {R,G,B}} after fill: R=i[7:4], G=i[3:0], B=~i[3:0]
  localparam logic [19:0] VEC [8] = '{
    20'h0000F, 20'h1313C, 20'h7A7A5, 20'hFFFF0,
    20'h8080F, 20'h3C3C3, 20'hA5A5A, 20'hC1C1E
  };

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idx_write(logic [7:0] v);
    @(negedge clk);
    reg_idx_sel = 1; reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_idx_sel = 0; reg_wr = 0;
  endtask

  task automatic data_write(logic [7:0] v);
    @(negedge clk);
    reg_data_sel = 1; reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_data_sel = 0; reg_wr = 0;
  endtask

  task automatic data_read(string tag, logic [7:0] exp);
    @(negedge clk);
    reg_data_sel = 1; reg_rd = 1;
    #1 chk(tag, {4'h0, reg_rdata}, {4'h0, exp});
    @(negedge clk);
    reg_data_sel = 0; reg_rd = 0;
  endtask

  task automatic lookup(string tag, logic [7:0] idx, logic [11:0] exp);
    @(negedge clk);
    px_valid = 1; px_index = idx;
    @(negedge clk);
    px_valid = 0;
    chk({tag, " valid"}, {11'h0, rgb_valid}, 12'h1);
    chk(tag, rgb_out, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of the pixel port
    chk("R1 rgb_valid", {11'h0, rgb_valid}, 12'h0);
    chk("R1 px_ready", {11'h0, px_ready}, 12'h1);
    rst_n = 1;

    // Fill every entry with one index write; low nibbles are junk (R6)
    idx_write(8'h00);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      e = 8'(i);
      data_write({e[7:4], 4'hA});
      data_write({e[3:0], 4'h5});
      data_write({~e[3:0], 4'hF});
    end
    // R4: the fill ran past entry 255; the pointer is back at entry 0, red
    data_read("R4 after fill R[0]", 8'h00);
    data_read("R4 after fill G[0]", 8'h00);
    data_read("R4 after fill B[0]", 8'hF0);

    // R9 vector table walk
    for (int k = 0; k < 8; k++)
      lookup("R9 vector", VEC[k][19:12], VEC[k][11:0]);

    // R1: mid-run reset puts the pointer at 0/red, tables kept
    idx_write(8'h77);
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    data_read("R1 ptr R[0]", 8'h00);
    data_read("R1 ptr G[0]", 8'h00);
    data_read("R1 ptr B[0]", 8'hF0);

    // R3 example: entry 3, then pointer at R[4]
    idx_write(8'h03);
    data_write(8'h9C); data_write(8'h63); data_write(8'h21);
    lookup("R3 entry 3", 8'h03, 12'h962);
    data_read("R3 next R[4]", 8'h00);
    data_read("R3 next G[4]", 8'h40);
    data_read("R3 next B[4]", 8'hB0);

    // R4: wrap from blue of 255 to red of 0
    idx_write(8'hFF);
    data_read("R4 R[255]", 8'hF0);
    data_read("R4 G[255]", 8'hF0);
    data_read("R4 B[255]", 8'h00);
    data_read("R4 wrap R[0]", 8'h00);
    data_read("R4 wrap G[0]", 8'h00);
    data_read("R4 wrap B[0]", 8'hF0);

    // R5: staged red/green invisible until blue
    idx_write(8'h20);
    data_write(8'hE0); data_write(8'hD0);
    lookup("R5 before blue", 8'h20, 12'h20F);
    data_write(8'h1F);
    lookup("R5 after blue", 8'h20, 12'hED1);

    // R8/R7: index write discards staged red; read gives committed value
    idx_write(8'h30);
    data_write(8'h80);
    idx_write(8'h30);
    data_read("R7 R[0x30] committed", 8'h30);
    data_read("R7 G[0x30]", 8'h00);
    data_write(8'h7F);
    lookup("R8 no stale red", 8'h30, 12'h307);

    // R10 back-pressure
    @(negedge clk);
    rgb_ready = 0; px_valid = 1; px_index = 8'h13;
    @(negedge clk);
    chk("R10 first out", rgb_out, 12'h13C);
    px_index = 8'h7A;
    chk("R10 px_ready low", {11'h0, px_ready}, 12'h0);
    @(negedge clk);
    chk("R10 held out", rgb_out, 12'h13C);
    chk("R10 held valid", {11'h0, rgb_valid}, 12'h1);
    rgb_ready = 1;
    @(negedge clk);
    px_valid = 0;
    chk("R10 released", rgb_out, 12'h7A5);
    @(negedge clk);
    chk("R10 drained", {11'h0, rgb_valid}, 12'h0);

    // R11: blue commit and lookup of the same entry in one cycle
    idx_write(8'h50);
    data_write(8'h10); data_write(8'h20);
    @(negedge clk);
    reg_data_sel = 1; reg_wr = 1; reg_wdata = 8'h30;
    px_valid = 1; px_index = 8'h50;
    @(negedge clk);
    reg_data_sel = 0; reg_wr = 0; px_valid = 0;
    chk("R11 same-cycle old", rgb_out, 12'h50F);
    lookup("R11 after commit", 8'h50, 12'h123);

    // R12: index write and data write together, index wins
    @(negedge clk);
    reg_idx_sel = 1; reg_data_sel = 1; reg_wr = 1; reg_wdata = 8'h60;
    @(negedge clk);
    reg_idx_sel = 0; reg_data_sel = 0; reg_wr = 0;
    data_read("R12 R[0x60]", 8'h60);
    data_read("R12 G[0x60]", 8'h00);
    lookup("R12 table untouched", 8'h60, 12'h60F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule